// File: doc/BRIEF.md
# Synchronous Burst Read Latency and WAIT Generator

This block is the read-side timing engine of a synchronous burst flash-style memory port. The host opens a burst by holding chip enable low and pulsing the address-valid strobe low for one clock with the start address on the address bus. The block latches that address and counts out a programmable initial latency. It then presents one 16-bit word per clock from an internal array model, walking upward through consecutive addresses.

The array is sensed one 16-word row at a time. When a burst runs off the end of a row into the next one, the block inserts stall cycles while the next row is fetched. During those stalls the data bus keeps its last word. A WAIT output, whose active level is chosen by a polarity input, is asserted in every cycle in which the bus does not carry a fresh, valid word. Raising chip enable ends the burst at once. The storage array is a combinational function of the address, so the timing can be checked against arithmetic expectations.

Top module: `nor_burst_reader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the bus-drive flag `dqEn` is 0, `dqOut` is 0 and `waitOut` is at its inactive level.
- R2: An address is captured only on a rising edge where `ceN` and `advN` are both 0. A low `advN` while `ceN` is 1 starts nothing: `dqEn` stays 0 and `waitOut` stays inactive.
- R3: With an effective latency L, WAIT is asserted and `dqEn` is 0 (with `dqOut` 0) for exactly the L cycles following the capture edge. The first word appears in the cycle after the L-th edge that follows capture.
- R4: A `latCode` value from 2 to 5 gives L equal to the code. Any other value of the 3-bit code gives L = 5.
- R5: Once streaming, each clock presents the next word. The word at address A is A XOR 16'h5A3C, and addresses increase by one per word.
- R6: When the next word would be at row offset 0 (address bits [3:0] = 0) and it is not the first word of the burst, L-1 stall cycles come first. During these, WAIT is asserted, `dqEn` stays 1 and `dqOut` holds the previous word.
- R7: With `waitHigh` = 1, WAIT is active-high. With `waitHigh` = 0, it is active-low. The inactive level is the inverse of the active one.
- R8: `ceN` sampled high on any edge ends the burst. From the next cycle, `dqEn` is 0, `dqOut` is 0 and WAIT is inactive.
- R9: A new capture (`ceN` and `advN` low) during a burst restarts the sequence. The new address is used and the latency count begins again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| advN | input | 1 | Address-valid strobe, active low |
| addrIn | input | 16 | Burst start address |
| latCode | input | 3 | Initial latency code |
| waitHigh | input | 1 | WAIT polarity: 1 selects active-high |
| dqOut | output | 16 | Read data; 0 while the bus is released |
| dqEn | output | 1 | 1 while the block drives the data bus |
| waitOut | output | 1 | WAIT, asserted while the bus holds no fresh valid word |

## Verification
The main sweep starts a 20-word burst at every row offset 0 to F, for all eight latency codes and both polarities. Varying the start offset changes where the first row crossing falls: immediately after the first word, mid-burst, or after a full row. This separates a stall placed on the wrong word from one of the wrong length. Codes 0, 1, 6 and 7 are set apart from the legal codes by the clamped latency of 5, and the two polarity settings show whether WAIT is inverted as a whole or only in some phases. Separate runs cover a chip-enable abort in the middle of a burst, a strobe given while chip enable is high, and a restart while streaming. These tell an ignored strobe, a true abort and a clean restart apart.

// File: rtl/nor_burst_pkg.sv
package nor_burst_pkg;

  localparam int unsigned LAT_CODE_W = 3;
  localparam int unsigned LAT_MIN    = 2;
  localparam int unsigned LAT_MAX    = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LAT    = 2'd1,
    PH_STREAM = 2'd2,
    PH_STALL  = 2'd3
  } phase_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // load start address
    logic advance;   // present word at current address, step address
    logic drive;     // bus is driven this cycle
  } strobe_t;

  // Clamp a latency code to its effective clock count.
  function automatic logic [LAT_CODE_W-1:0] effLatency(input logic [LAT_CODE_W-1:0] code);
    if (code >= LAT_CODE_W'(LAT_MIN) && code <= LAT_CODE_W'(LAT_MAX))
      return code;
    return LAT_CODE_W'(LAT_MAX);
  endfunction

endpackage

// File: rtl/nor_burst_ctrl.sv
module nor_burst_ctrl
  import nor_burst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  advN,
  input  logic [LAT_CODE_W-1:0] latCode,
  input  logic                  rowStart,
  output strobe_t               strb,
  output logic                  waitAct
);

  phase_t                phase, phaseNxt;
  logic [LAT_CODE_W-1:0] cnt, cntNxt;
  logic [LAT_CODE_W-1:0] latReg, latNxt;
  logic                  advanceNxt, captureNxt;

  always_comb begin
    phaseNxt   = phase;
    cntNxt     = cnt;
    latNxt     = latReg;
    advanceNxt = 1'b0;
    captureNxt = 1'b0;
    if (ceN) begin
      phaseNxt = PH_IDLE;
      cntNxt   = '0;
    end else if (!advN) begin
      captureNxt = 1'b1;
      latNxt     = effLatency(latCode);
      cntNxt     = effLatency(latCode);
      phaseNxt   = PH_LAT;
    end else begin
      unique case (phase)
        PH_LAT, PH_STALL: begin
          if (cnt == LAT_CODE_W'(1)) begin
            advanceNxt = 1'b1;
            phaseNxt   = PH_STREAM;
          end else begin
            cntNxt = cnt - LAT_CODE_W'(1);
          end
        end
        PH_STREAM: begin
          if (rowStart) begin
            phaseNxt = PH_STALL;
            cntNxt   = latReg - LAT_CODE_W'(1);
          end else begin
            advanceNxt = 1'b1;
          end
        end
        default: begin
          phaseNxt = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      latReg <= LAT_CODE_W'(LAT_MAX);
    end else begin
      phase  <= phaseNxt;
      cnt    <= cntNxt;
      latReg <= latNxt;
    end
  end

  always_comb begin
    strb.capture = captureNxt;
    strb.advance = advanceNxt;
    strb.drive   = (phase == PH_STREAM) || (phase == PH_STALL);
    waitAct      = (phase == PH_LAT) || (phase == PH_STALL);
  end

endmodule

// File: rtl/nor_burst_datapath.sv
module nor_burst_datapath
  import nor_burst_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 16,
  parameter int unsigned          DATA_W    = 16,
  parameter int unsigned          ROW_WORDS = 16,
  parameter logic [DATA_W-1:0]    KEY       = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  strobe_t           strb,
  output logic              rowStart,
  output logic [DATA_W-1:0] dqOut
);

  localparam int unsigned OFS_W = $clog2(ROW_WORDS);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] arrayWord;

  // Array model: word is the address, widened or trimmed, XOR a key.
  generate
    if (ADDR_W >= DATA_W) begin : g_trim
      assign arrayWord = addrReg[DATA_W-1:0] ^ KEY;
    end else begin : g_widen
      assign arrayWord = {{(DATA_W-ADDR_W){1'b0}}, addrReg} ^ KEY;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else if (strb.capture) begin
      addrReg <= addrIn;
    end else if (strb.advance) begin
      dataReg <= arrayWord;
      addrReg <= addrReg + ADDR_W'(1);
    end
  end

  assign rowStart = (addrReg[OFS_W-1:0] == '0);
  assign dqOut    = strb.drive ? dataReg : '0;

endmodule

// File: rtl/nor_burst_reader.sv
module nor_burst_reader
  import nor_burst_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       ROW_WORDS = 16,
  parameter logic [DATA_W-1:0] KEY       = 16'h5A3C
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  advN,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [LAT_CODE_W-1:0] latCode,
  input  logic                  waitHigh,
  output logic [DATA_W-1:0]     dqOut,
  output logic                  dqEn,
  output logic                  waitOut
);

  strobe_t strb;
  logic    rowStart;
  logic    waitAct;

  nor_burst_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .advN     (advN),
    .latCode  (latCode),
    .rowStart (rowStart),
    .strb     (strb),
    .waitAct  (waitAct)
  );

  nor_burst_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ROW_WORDS (ROW_WORDS),
    .KEY       (KEY)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (addrIn),
    .strb     (strb),
    .rowStart (rowStart),
    .dqOut    (dqOut)
  );

  assign dqEn    = strb.drive;
  assign waitOut = waitAct ~^ waitHigh;

endmodule

// File: rtl/nor_burst_checker.sv
module nor_burst_checker #(
  parameter int unsigned       DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY    = 16'h5A3C
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              advN,
  input logic              waitHigh,
  input logic [DATA_W-1:0] dqOut,
  input logic              dqEn,
  input logic              waitOut
);

  // R8: chip enable high ends the burst on the next cycle
  a_r8_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!dqEn && (waitOut != waitHigh)));

  // R2 / R3: a capture is followed by a latency cycle with WAIT active
  a_r3_capture_waits: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !advN) |=> (!dqEn && (waitOut == waitHigh)));

  // R3: a released bus reads as zero
  a_r3_released_zero: assert property (@(posedge clk) disable iff (!rstN)
    !dqEn |-> (dqOut == '0));

  // R6: a stall cycle on a driven bus keeps the previous word
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dqEn && $past(dqEn) && (waitOut == waitHigh) && $past(!ceN && advN)) |-> $stable(dqOut));

  // R5: a valid word followed by another valid word steps the address by one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (dqEn && (waitOut != waitHigh) && !ceN && advN) |=>
      ((dqEn && (waitOut != waitHigh)) ->
        ((dqOut ^ KEY) == (($past(dqOut) ^ KEY) + DATA_W'(1)))));

endmodule

bind nor_burst_reader nor_burst_checker #(
  .DATA_W (DATA_W),
  .KEY    (KEY)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .advN     (advN),
  .waitHigh (waitHigh),
  .dqOut    (dqOut),
  .dqEn     (dqEn),
  .waitOut  (waitOut)
);

// File: tb/nor_burst_reader_tb.sv
module nor_burst_reader_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1;
  logic        advN = 1'b1;
  logic [15:0] addrIn = '0;
  logic [2:0]  latCode = 3'd2;
  logic        waitHigh = 1'b0;
  logic [15:0] dqOut;
  logic        dqEn;
  logic        waitOut;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycCnt   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  nor_burst_reader dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .advN     (advN),
    .addrIn   (addrIn),
    .latCode  (latCode),
    .waitHigh (waitHigh),
    .dqOut    (dqOut),
    .dqEn     (dqEn),
    .waitOut  (waitOut)
  );

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > 150000 && !finished) begin
      finished = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cycCnt);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  function automatic int effLat(input int code);
    return (code >= 2 && code <= 5) ? code : 5;
  endfunction

  function automatic logic [15:0] wordAt(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  // Compare outputs now (called at a falling edge).
  task automatic checkNow(input bit act, input bit en, input logic [15:0] data,
                          input string req);
    logic expWait;
    logic [15:0] expData;
    expWait = act ? waitHigh : ~waitHigh;
    expData = en ? data : 16'h0000;
    checkCnt++;
    if (waitOut !== expWait || dqEn !== en || dqOut !== expData) begin
      failCnt++;
      $display("FAIL %s: actual wait=%b en=%b dq=%h expected wait=%b en=%b dq=%h",
               req, waitOut, dqEn, dqOut, expWait, en, expData);
    end
  endtask

  task automatic stepCheck(input bit act, input bit en, input logic [15:0] data,
                           input string req);
    @(posedge clk);
    @(negedge clk);
    checkNow(act, en, data, req);
  endtask

  // Start a burst at a falling edge and check every cycle of it.
  task automatic runBurst(input bit pol, input int code, input logic [15:0] start,
                          input int nWords, input bit doAbort);
    int lat;
    lat      = effLat(code);
    waitHigh = pol;
    latCode  = 3'(code);
    addrIn   = start;
    ceN      = 1'b0;
    advN     = 1'b0;
    stepCheck(1'b1, 1'b0, 16'h0, "R2 capture");
    advN = 1'b1;
    for (int t = 1; t < lat; t++)
      stepCheck(1'b1, 1'b0, 16'h0, (code >= 2 && code <= 5) ? "R3 latency" : "R4 clamp");
    for (int i = 0; i < nWords; i++) begin
      logic [15:0] a;
      a = start + 16'(i);
      if (i > 0 && a[3:0] == 4'h0) begin
        for (int s = 0; s < lat - 1; s++)
          stepCheck(1'b1, 1'b1, wordAt(a - 16'd1), "R6 row stall");
      end
      stepCheck(1'b0, 1'b1, wordAt(a), pol ? "R5 word R7 high" : "R5 word R7 low");
    end
    if (doAbort) begin
      ceN = 1'b1;
      stepCheck(1'b0, 1'b0, 16'h0, "R8 abort");
    end
  endtask

  initial begin
    waitHigh = 1'b1;
    repeat (3) @(negedge clk);
    checkNow(1'b0, 1'b0, 16'h0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkNow(1'b0, 1'b0, 16'h0, "R1 after reset");

    // R2: strobe ignored while chip enable is high
    ceN = 1'b1; advN = 1'b0; addrIn = 16'h0042;
    stepCheck(1'b0, 1'b0, 16'h0, "R2 ignored");
    advN = 1'b1;
    stepCheck(1'b0, 1'b0, 16'h0, "R2 ignored");

    // Main sweep: polarity x code x start offset (R3 R4 R5 R6 R7)
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 8; c++)
        for (int o = 0; o < 16; o++)
          runBurst(p[0], c, 16'h1230 + 16'(c * 64) + 16'(o), 20, 1'b1);

    // Address wrap at the top of the space
    runBurst(1'b0, 3, 16'hFFFD, 6, 1'b1);

    // R8: abort mid-latency
    waitHigh = 1'b0; latCode = 3'd5; addrIn = 16'h0300; ceN = 1'b0; advN = 1'b0;
    stepCheck(1'b1, 1'b0, 16'h0, "R8 pre-abort");
    advN = 1'b1;
    stepCheck(1'b1, 1'b0, 16'h0, "R8 pre-abort");
    ceN = 1'b1;
    stepCheck(1'b0, 1'b0, 16'h0, "R8 abort in latency");
    stepCheck(1'b0, 1'b0, 16'h0, "R8 stays idle");

    // R9: restart while streaming, then again during a stall
    runBurst(1'b1, 2, 16'h0500, 5, 1'b0);
    runBurst(1'b1, 4, 16'h0A0E, 3, 1'b0);
    runBurst(1'b0, 3, 16'h0C07, 12, 1'b1);
    // R9 restart lands on a stall cycle (word F presented, stall pending)
    runBurst(1'b1, 5, 16'h0D0F, 1, 1'b0);
    stepCheck(1'b1, 1'b1, wordAt(16'h0D0F), "R9 stall before restart");
    runBurst(1'b1, 2, 16'h0E00, 4, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule